// File: doc/BRIEF.md
# Smart-Card Receive Character Buffer

This block holds characters that a smart-card character receiver has taken off the serial line until the host CPU fetches them. Every entry keeps the received byte together with a one-bit parity verdict. The receiver pulses a write strobe for each character. The register interface pulses a read strobe when the host reads the data word, and another strobe when the host reads the interrupt status.

A programmable threshold raises a sticky ready flag once the buffer holds more characters than the threshold. That flag clears only when the host reads the data word. A character that arrives with no room is dropped and raises a sticky overflow flag. Both flags drive one interrupt line, and each flag has its own mask bit.

A synchronous interface reset returns the whole block to its empty state.

Top module: `card_rx_fifo`

## Requirements
- R1: After reset, fifoEmpty is 1, and fifoFull, rdyFlag, ovfFlag and irq are all 0.
- R2: Characters are returned in arrival order. rdWord[7:0] shows the oldest stored byte, and rdWord[8] shows its parity flag, while fifoEmpty is 0. A rdData pulse removes that entry.
- R3: The parity flag is captured at write time. It is wrParOk when parChkEn is 1 and it is 1 (OK) when parChkEn is 0.
- R4: fifoFull is 1 exactly when DEPTH (16) entries are held. fifoEmpty is 1 exactly when none are held.
- R5: rdyFlag becomes 1 one clock after the stored count exceeds trigLevel, and it stays 1 until a rdData pulse.
- R6: A rdData pulse clears rdyFlag on that clock edge. The flag is then re-evaluated against the new count from the next edge on.
- R7: A wrStrobe while fifoFull is 1 drops the character, leaves the stored contents unchanged, and sets ovfFlag, which stays set.
- R8: A rdIntStat pulse clears ovfFlag, unless an overflow happens in the same cycle.
- R9: irq equals (rdyFlag AND NOT maskRdy) OR (ovfFlag AND NOT maskOvf). A mask bit of 1 suppresses its source.
- R10: An ifReset pulse empties the buffer and clears rdyFlag and ovfFlag on the next edge.
- R11: When the buffer is neither empty nor full, a write and a read in the same cycle both take effect and the count stays the same. A read while empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ifReset | input | 1 | Synchronous interface reset |
| wrStrobe | input | 1 | Character received, store it |
| wrData | input | 8 | Received byte |
| wrParOk | input | 1 | Receiver parity verdict, 1 = OK |
| rdData | input | 1 | Host read of the data word |
| rdIntStat | input | 1 | Host read of the interrupt status |
| parChkEn | input | 1 | Parity checking enable |
| trigLevel | input | 4 | Ready threshold |
| maskRdy | input | 1 | 1 masks the ready interrupt |
| maskOvf | input | 1 | 1 masks the overflow interrupt |
| rdWord | output | 9 | {parity flag, byte} of the oldest entry |
| fifoFull | output | 1 | 1 = full |
| fifoEmpty | output | 1 | 1 = empty |
| rdyFlag | output | 1 | Sticky receive-ready flag |
| ovfFlag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its default values: a depth of 16, 8-bit data and a 4-bit threshold. With this depth, the full boundary and a dropped seventeenth character can be reached in a few dozen cycles. It also lets the threshold be set both at its maximum of 15 and at small values. The bench therefore sees the ready flag fire at exactly 16 entries, and it sees the flag stay low just at and below a small threshold.

// File: rtl/card_rx_pkg.sv
package card_rx_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoCtl_t;
endpackage

// File: rtl/card_rx_store.sv
module card_rx_store
  import card_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoCtl_t      ctl,
  input  logic [DW-1:0] wrData,
  input  logic          wrParOk,
  input  logic          parChkEn,
  output logic [DW:0]   rdWord,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrPtr] <= {wrParOk | ~parChkEn, wrData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrPtr <= nextPtr(wrPtr);
      if (ctl.pop)  rdPtr <= nextPtr(rdPtr);
      case ({ctl.push, ctl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdWord = mem[rdPtr];
  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
endmodule

// File: rtl/card_rx_ctrl.sv
module card_rx_ctrl
  import card_rx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TRIG_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ifReset,
  input  logic              wrStrobe,
  input  logic              rdData,
  input  logic              rdIntStat,
  input  logic [TRIG_W-1:0] trigLevel,
  input  logic              maskRdy,
  input  logic              maskOvf,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic              full,
  input  logic              empty,
  output fifoCtl_t          ctl,
  output logic              rdyFlag,
  output logic              ovfFlag,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int XW = (CW > TRIG_W) ? CW : TRIG_W;

  logic overTrig;
  logic ovfEvent;

  assign overTrig  = XW'(count) > XW'(trigLevel);
  assign ovfEvent  = wrStrobe & full;
  assign ctl.flush = ifReset;
  assign ctl.push  = wrStrobe & ~full & ~ifReset;
  assign ctl.pop   = rdData & ~empty & ~ifReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdyFlag <= 1'b0;
      ovfFlag <= 1'b0;
    end else if (ifReset) begin
      rdyFlag <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (rdData)        rdyFlag <= 1'b0;
      else if (overTrig) rdyFlag <= 1'b1;
      if (ovfEvent)       ovfFlag <= 1'b1;
      else if (rdIntStat) ovfFlag <= 1'b0;
    end
  end

  assign irq = (rdyFlag & ~maskRdy) | (ovfFlag & ~maskOvf);
endmodule

// File: rtl/card_rx_fifo.sv
module card_rx_fifo
  import card_rx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DW     = 8,
  parameter int TRIG_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ifReset,
  input  logic              wrStrobe,
  input  logic [DW-1:0]     wrData,
  input  logic              wrParOk,
  input  logic              rdData,
  input  logic              rdIntStat,
  input  logic              parChkEn,
  input  logic [TRIG_W-1:0] trigLevel,
  input  logic              maskRdy,
  input  logic              maskOvf,
  output logic [DW:0]       rdWord,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              rdyFlag,
  output logic              ovfFlag,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);

  fifoCtl_t      ctl;
  logic [CW-1:0] count;

  card_rx_ctrl #(.DEPTH(DEPTH), .TRIG_W(TRIG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ifReset(ifReset), .wrStrobe(wrStrobe),
    .rdData(rdData), .rdIntStat(rdIntStat), .trigLevel(trigLevel),
    .maskRdy(maskRdy), .maskOvf(maskOvf), .count(count),
    .full(fifoFull), .empty(fifoEmpty), .ctl(ctl),
    .rdyFlag(rdyFlag), .ovfFlag(ovfFlag), .irq(irq)
  );

  card_rx_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .wrParOk(wrParOk), .parChkEn(parChkEn), .rdWord(rdWord),
    .count(count), .full(fifoFull), .empty(fifoEmpty)
  );
endmodule

// File: rtl/card_rx_fifo_chk.sv
module card_rx_fifo_chk (
  input logic clk,
  input logic rstN,
  input logic ifReset,
  input logic wrStrobe,
  input logic rdData,
  input logic rdIntStat,
  input logic maskRdy,
  input logic maskOvf,
  input logic fifoFull,
  input logic fifoEmpty,
  input logic rdyFlag,
  input logic ovfFlag,
  input logic irq
);
  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe && fifoFull && !ifReset |=> ovfFlag);
  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe && fifoFull && !rdData && !ifReset |=> fifoFull);
  // R8
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdIntStat && !(wrStrobe && fifoFull) && !ifReset |=> !ovfFlag);
  // R6
  rdy_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData && !ifReset |=> !rdyFlag);
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskRdy && maskOvf |-> !irq);
  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    ifReset |=> fifoEmpty && !rdyFlag && !ovfFlag);
  // R11
  both_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe && rdData && !fifoFull && !fifoEmpty && !ifReset
    |=> $stable(fifoEmpty) && $stable(fifoFull));
endmodule

bind card_rx_fifo card_rx_fifo_chk u_chk (.*);

// File: tb/sim_card_rx_fifo.sv
module sim_card_rx_fifo;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ifReset = 1'b0, wrStrobe = 1'b0, wrParOk = 1'b0;
  logic rdData = 1'b0, rdIntStat = 1'b0, parChkEn = 1'b1;
  logic maskRdy = 1'b0, maskOvf = 1'b0;
  logic [7:0] wrData = '0;
  logic [3:0] trigLevel = 4'd15;
  logic [8:0] rdWord;
  logic fifoFull, fifoEmpty, rdyFlag, ovfFlag, irq;

  int nRun = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_rx_fifo u0 (
    .clk(clk), .rstN(rstN), .ifReset(ifReset), .wrStrobe(wrStrobe),
    .wrData(wrData), .wrParOk(wrParOk), .rdData(rdData),
    .rdIntStat(rdIntStat), .parChkEn(parChkEn), .trigLevel(trigLevel),
    .maskRdy(maskRdy), .maskOvf(maskOvf), .rdWord(rdWord),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .rdyFlag(rdyFlag),
    .ovfFlag(ovfFlag), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b, input logic p);
    @(negedge clk);
    wrStrobe = 1'b1; wrData = b; wrParOk = p;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    rdData = 1'b1;
    @(negedge clk);
    rdData = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    ifReset = 1'b1;
    @(negedge clk);
    ifReset = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 empty", fifoEmpty, 1);
    chk("R1 full", fifoFull, 0);
    chk("R1 rdy", rdyFlag, 0);
    chk("R1 ovf", ovfFlag, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_order();
    trigLevel = 4'd15; parChkEn = 1'b1;
    push(8'hA5, 1'b1);
    push(8'h3C, 1'b0);
    push(8'hFF, 1'b1);
    chk("R2 head0", rdWord, 9'h1A5);
    pop();
    chk("R3 head1 parity err", rdWord, 9'h03C);
    pop();
    chk("R2 head2", rdWord, 9'h1FF);
    pop();
    chk("R4 empty after drain", fifoEmpty, 1);
  endtask

  task automatic t_parOff();
    parChkEn = 1'b0;
    push(8'h55, 1'b0);
    chk("R3 parity forced ok", rdWord, 9'h155);
    parChkEn = 1'b1;
    pop();
  endtask

  task automatic t_trig();
    trigLevel = 4'd2; maskRdy = 1'b0; maskOvf = 1'b0;
    push(8'h01, 1'b1);
    push(8'h02, 1'b1);
    idle();
    chk("R5 at trigger no rdy", rdyFlag, 0);
    push(8'h03, 1'b1);
    idle();
    chk("R5 above trigger rdy", rdyFlag, 1);
    chk("R9 irq unmasked", irq, 1);
    maskRdy = 1'b1;
    #1;
    chk("R9 irq masked", irq, 0);
    chk("R9 flag kept when masked", rdyFlag, 1);
    maskRdy = 1'b0;
    pop();
    chk("R6 rdy cleared by read", rdyFlag, 0);
    idle();
    chk("R6 stays low at trigger", rdyFlag, 0);
    chk("R2 head after read", rdWord, 9'h102);
    flush();
  endtask

  task automatic t_full();
    trigLevel = 4'd15; maskRdy = 1'b1; maskOvf = 1'b0; parChkEn = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (i == 15) chk("R4 not full at 15", fifoFull, 0);
      push(8'h10 + 8'(i), i[0]);
    end
    chk("R4 full at 16", fifoFull, 1);
    chk("R4 not empty", fifoEmpty, 0);
    chk("R7 no ovf yet", ovfFlag, 0);
    idle();
    chk("R5 rdy at 16 over 15", rdyFlag, 1);
    push(8'h99, 1'b1);
    chk("R7 ovf set", ovfFlag, 1);
    chk("R9 ovf irq", irq, 1);
    idle();
    chk("R7 ovf sticky", ovfFlag, 1);
    @(negedge clk); rdIntStat = 1'b1;
    @(negedge clk); rdIntStat = 1'b0;
    chk("R8 ovf cleared", ovfFlag, 0);
    chk("R8 irq off", irq, 0);
    for (int i = 0; i < 16; i++) begin
      chk($sformatf("R7 content %0d", i), rdWord, {i[0], 8'h10 + 8'(i)});
      pop();
    end
    chk("R4 empty after 16 reads", fifoEmpty, 1);
    maskRdy = 1'b0;
  endtask

  task automatic t_both();
    trigLevel = 4'd15;
    push(8'h21, 1'b1);
    push(8'h22, 1'b1);
    @(negedge clk);
    wrStrobe = 1'b1; wrData = 8'h23; wrParOk = 1'b1; rdData = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0; rdData = 1'b0;
    chk("R11 head after both", rdWord, 9'h122);
    pop();
    chk("R11 next", rdWord, 9'h123);
    pop();
    chk("R11 two left then empty", fifoEmpty, 1);
    pop();
    push(8'h44, 1'b1);
    chk("R11 empty read ignored", rdWord, 9'h144);
    pop();
    chk("R11 empty again", fifoEmpty, 1);
  endtask

  task automatic t_flush();
    trigLevel = 4'd0;
    push(8'h77, 1'b1);
    push(8'h78, 1'b1);
    idle();
    chk("R5 rdy trig0", rdyFlag, 1);
    flush();
    chk("R10 empty", fifoEmpty, 1);
    chk("R10 rdy clear", rdyFlag, 0);
    chk("R10 ovf clear", ovfFlag, 0);
    trigLevel = 4'd15;
    push(8'h5A, 1'b1);
    chk("R10 restart head", rdWord, 9'h15A);
    pop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();
    t_reset();
    t_order();
    t_parOff();
    t_trig();
    t_full();
    t_both();
    t_flush();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule